// File: doc/BRIEF.md
# Framebuffer Mode Register Window

A small memory-mapped register window for a simple display adapter. It holds 128 bytes of little-endian storage. The first twelve bytes carry the framebuffer size, the active width and height, the colour depth and the refresh rate. The remaining bytes are general storage that the adapter's driver may use. A host reaches the window through a valid/ready port. Each access is 1, 2, 4 or 8 bytes wide and may start at any byte offset. Accesses that run past the end of the window, or that use an unsupported size, are dropped: a write changes nothing and a read returns zero.

Every accepted write is followed by a mode decision. Clearing both dimensions to zero moves the adapter into legacy VGA mode. Setting both to non-zero values brings it back to linear-framebuffer mode. Any mixed state leaves the mode as it was, so the flag has hysteresis. While in linear mode, the block keeps a record of the resolution that was last applied to the display. When the register dimensions differ from that record, it raises a one-cycle resize request and copies the new dimensions into the record.

Top module: `fb_mode_regs`

## Requirements
- R1: The window is 128 bytes long. An access whose start offset plus byte count exceeds 128 is dropped: a write changes no byte, and a read returns zero.
- R2: The storage is little-endian, with the lowest address in data bits 7:0. Byte offset 0 holds a 32-bit framebuffer size, offset 4 the 16-bit width, offset 6 the 16-bit height, offset 8 the 16-bit depth and offset 10 the 16-bit refresh rate. Offsets 12 to 127 are plain read/write storage.
- R3: `req_size` gives the byte count and must be 1, 2, 4 or 8. Any other value writes nothing and reads zero.
- R4: After reset the framebuffer size reads 0x01000000, the width 1024, the height 768 and the depth 32, and every other byte reads 0. `vga_mode` is 0, the applied resolution is 1024x768 and `resize_req` is 0.
- R5: An accepted write made in linear mode that leaves both width and height at zero sets `vga_mode` at the same clock edge and clears the applied width and height to 0.
- R6: An accepted write made in VGA mode that leaves both width and height non-zero clears `vga_mode` at the same clock edge. In every other case, including all cycles without a write, the mode holds.
- R7: While `vga_mode` is 0, a difference between the register width/height and the applied width/height raises `resize_req` for one cycle. At the same edge the applied values take the register values. `resize_req` is never high while `vga_mode` is 1.
- R8: `req_ready` is always 1. Each accepted request gives `rsp_valid` exactly one cycle later. `rsp_rdata` carries the read data for a valid read and zero otherwise.
- R9: If the default width or height parameter is 0, the reset value becomes 1920 or 1080 respectively.
- R10: An 8-byte write updates all eight bytes, spanning two 32-bit words, at one clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset into the window |
| req_size | input | 4 | Access byte count |
| req_wdata | input | 64 | Write data, little-endian |
| rsp_valid | output | 1 | Response one cycle after a request |
| rsp_rdata | output | 64 | Read data, zero for writes and dropped reads |
| vga_mode | output | 1 | 1 = legacy VGA mode, 0 = linear mode |
| resize_req | output | 1 | One-cycle resize request |
| disp_width | output | 16 | Applied display width |
| disp_height | output | 16 | Applied display height |

## Verification
The hardest situation to reach is where a single write both completes a mode transition and meets a resize that is still pending from the previous write. It is also hard to cover every mixed width/height state that must leave the mode untouched. The random stimulus biases write data toward zero and aims many accesses at offsets 0 to 8 with every access size, so partial writes that zero only one dimension occur often. Directed sequences walk the full path: linear mode, then VGA, then one dimension set, then the other, then the resize. Accesses that straddle the 128-byte end of the window check that dropped writes leave neighbouring bytes intact.

// File: rtl/fb_mode_regs.sv
module fb_mode_regs #(
  parameter int ADDR_W    = 8,
  parameter int WIN_BYTES = 128,
  parameter int FB_BYTES  = 32'h0100_0000,
  parameter int DEF_W     = 1024,
  parameter int DEF_H     = 768,
  parameter int DEF_DEPTH = 32,
  parameter int ZERO_W    = 1920,
  parameter int ZERO_H    = 1080
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_size,
  input  logic [63:0]       req_wdata,
  output logic              rsp_valid,
  output logic [63:0]       rsp_rdata,
  output logic              vga_mode,
  output logic              resize_req,
  output logic [15:0]       disp_width,
  output logic [15:0]       disp_height
);
  localparam int EW     = ADDR_W + 1;
  localparam int IDX_W  = $clog2(WIN_BYTES);
  localparam int INIT_W = (DEF_W == 0) ? ZERO_W : DEF_W;
  localparam int INIT_H = (DEF_H == 0) ? ZERO_H : DEF_H;
  localparam logic [95:0] INIT_VEC =
    {16'd0, 16'(DEF_DEPTH), 16'(INIT_H), 16'(INIT_W), 32'(FB_BYTES)};

  logic [7:0] mem     [WIN_BYTES];
  logic [7:0] mem_nxt [WIN_BYTES];
  logic [EW-1:0] addr_x, end_addr;
  logic size_ok, acc_ok, wr_ok, rd_ok;
  logic [63:0] rd_bytes;
  logic [15:0] cur_w, cur_h, nxt_w, nxt_h;
  logic enter_vga, leave_vga, mismatch;

  assign req_ready = 1'b1;
  assign addr_x    = {1'b0, req_addr};
  assign end_addr  = addr_x + {{(EW-4){1'b0}}, req_size};
  assign size_ok   = (req_size == 4'd1) || (req_size == 4'd2) ||
                     (req_size == 4'd4) || (req_size == 4'd8);
  assign acc_ok    = size_ok && (end_addr <= EW'(WIN_BYTES));
  assign wr_ok     = req_valid && req_write && acc_ok;
  assign rd_ok     = req_valid && !req_write && acc_ok;

  always_comb begin
    for (int i = 0; i < WIN_BYTES; i++) begin
      mem_nxt[i] = mem[i];
      if (wr_ok && EW'(i) >= addr_x && EW'(i) < end_addr)
        mem_nxt[i] = req_wdata[8*int'(3'(EW'(i) - addr_x)) +: 8];
    end
  end

  always_comb begin
    for (int k = 0; k < 8; k++)
      rd_bytes[8*k +: 8] = (rd_ok && 4'(k) < req_size) ?
                           mem[IDX_W'(addr_x + EW'(k))] : 8'h00;
  end

  assign cur_w = {mem[5], mem[4]};
  assign cur_h = {mem[7], mem[6]};
  assign nxt_w = {mem_nxt[5], mem_nxt[4]};
  assign nxt_h = {mem_nxt[7], mem_nxt[6]};

  assign enter_vga = wr_ok && !vga_mode && nxt_w == 16'd0 && nxt_h == 16'd0;
  assign leave_vga = wr_ok &&  vga_mode && nxt_w != 16'd0 && nxt_h != 16'd0;
  assign mismatch  = !vga_mode && (cur_w != disp_width || cur_h != disp_height);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WIN_BYTES; i++)
        mem[i] <= (i < 12) ? INIT_VEC[8*i +: 8] : 8'h00;
    end else begin
      for (int i = 0; i < WIN_BYTES; i++)
        mem[i] <= mem_nxt[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= rd_bytes;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vga_mode    <= 1'b0;
      resize_req  <= 1'b0;
      disp_width  <= 16'(INIT_W);
      disp_height <= 16'(INIT_H);
    end else if (enter_vga) begin
      vga_mode    <= 1'b1;
      resize_req  <= 1'b0;
      disp_width  <= '0;
      disp_height <= '0;
    end else begin
      if (leave_vga) vga_mode <= 1'b0;
      resize_req <= mismatch;
      if (mismatch) begin
        disp_width  <= cur_w;
        disp_height <= cur_h;
      end
    end
  end

  // R8
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R8
  rsp_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R1
  oob_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && end_addr > EW'(WIN_BYTES)) |=> rsp_rdata == 64'd0);
  // R7
  resize_linear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resize_req |-> !vga_mode);
  // R5
  vga_entry_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vga_mode) |-> (disp_width == 16'd0 && disp_height == 16'd0));
  // R6
  mode_holds_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write) |=> $stable(vga_mode));
endmodule

// File: tb/fb_mode_regs_tb.sv
`timescale 1ns/1ps
module fb_mode_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [3:0]  req_size = '0;
  logic [63:0] req_wdata = '0;
  logic        req_ready, rsp_valid, vga_mode, resize_req;
  logic [63:0] rsp_rdata;
  logic [15:0] disp_width, disp_height;
  logic        z_ready, z_rv, z_vga, z_rs;
  logic [63:0] z_rd;
  logic [15:0] z_w, z_h;

  int errors = 0, checks = 0;
  logic [7:0] m_mem [128];
  logic m_vga, m_resize, m_rvalid;
  logic [15:0] m_aw, m_ah;
  logic [63:0] m_rdata;
  string rd_tag = "R2";

  always #2.5 clk = ~clk;

  fb_mode_regs dut_i (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .vga_mode(vga_mode), .resize_req(resize_req),
    .disp_width(disp_width), .disp_height(disp_height));

  fb_mode_regs #(.DEF_W(0), .DEF_H(0)) dut_z (.clk(clk), .rst_n(rst_n), .req_valid(1'b0),
    .req_ready(z_ready), .req_write(1'b0), .req_addr(8'd0), .req_size(4'd0), .req_wdata(64'd0),
    .rsp_valid(z_rv), .rsp_rdata(z_rd), .vga_mode(z_vga), .resize_req(z_rs),
    .disp_width(z_w), .disp_height(z_h));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit size_good(input logic [3:0] s);
    return s == 1 || s == 2 || s == 4 || s == 8;
  endfunction

  task automatic model_reset();
    logic [95:0] iv;
    iv = {16'd0, 16'd32, 16'd768, 16'd1024, 32'h0100_0000};
    for (int i = 0; i < 128; i++) m_mem[i] = (i < 12) ? iv[8*i +: 8] : 8'h00;
    m_vga = 0; m_resize = 0; m_rvalid = 0; m_rdata = 0; m_aw = 1024; m_ah = 768;
  endtask

  task automatic step(input bit v, input bit w, input int addr, input int sz, input logic [63:0] d);
    logic [15:0] cw, ch, nw, nh;
    bit ok, mis, ent, lv, oob, bad;
    string tag;
    req_valid = v; req_write = w; req_addr = 8'(addr); req_size = 4'(sz); req_wdata = d;
    oob = (addr + sz > 128);
    bad = !size_good(4'(sz));
    ok = !oob && !bad;
    cw = {m_mem[5], m_mem[4]}; ch = {m_mem[7], m_mem[6]};
    mis = !m_vga && (cw != m_aw || ch != m_ah);
    m_rvalid = v;
    m_rdata = 0;
    if (v && !w && ok)
      for (int k = 0; k < sz; k++) m_rdata[8*k +: 8] = m_mem[addr + k];
    if (v && w && ok)
      for (int k = 0; k < sz; k++) m_mem[addr + k] = d[8*k +: 8];
    nw = {m_mem[5], m_mem[4]}; nh = {m_mem[7], m_mem[6]};
    ent = v && w && ok && !m_vga && nw == 0 && nh == 0;
    lv  = v && w && ok && m_vga && nw != 0 && nh != 0;
    if (ent) begin m_vga = 1; m_resize = 0; m_aw = 0; m_ah = 0; end
    else begin
      if (lv) m_vga = 0;
      m_resize = mis;
      if (mis) begin m_aw = cw; m_ah = ch; end
    end
    tag = oob ? "R1" : (bad ? "R3" : rd_tag);
    @(posedge clk); #1;
    chk(vga_mode == m_vga, "R5/R6", "vga_mode", 64'(vga_mode), 64'(m_vga));
    chk(resize_req == m_resize, "R7", "resize_req", 64'(resize_req), 64'(m_resize));
    chk(disp_width == m_aw, "R7", "disp_width", 64'(disp_width), 64'(m_aw));
    chk(disp_height == m_ah, "R7", "disp_height", 64'(disp_height), 64'(m_ah));
    chk(rsp_valid == m_rvalid, "R8", "rsp_valid", 64'(rsp_valid), 64'(m_rvalid));
    chk(rsp_rdata == m_rdata, tag, "rsp_rdata", rsp_rdata, m_rdata);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R4 reset state
    chk(vga_mode == 0 && resize_req == 0, "R4", "reset flags", {vga_mode, resize_req}, 0);
    chk(disp_width == 1024 && disp_height == 768, "R4", "reset applied size",
        {disp_width, disp_height}, {16'd1024, 16'd768});
    chk(req_ready == 1, "R8", "req_ready", 64'(req_ready), 1);
    // R9 zero defaults substituted
    chk(z_w == 1920 && z_h == 1080, "R9", "zero-default size", {z_w, z_h}, {16'd1920, 16'd1080});
    @(negedge clk);
    rd_tag = "R4";
    step(1, 0, 0, 8, 0);
    step(1, 0, 8, 8, 0);
    step(1, 0, 12, 4, 0);
    step(0, 0, 0, 0, 0);
    rd_tag = "R2";
    step(1, 0, 4, 2, 0);
    step(1, 0, 6, 1, 0);
    step(1, 0, 8, 2, 0);
    // R5 clear both dims in linear mode
    step(1, 1, 4, 4, 64'h0);
    step(1, 0, 4, 4, 0);
    // R6 one dim set stays VGA, then both set leaves VGA, then R7 resize
    step(1, 1, 4, 2, 64'd800);
    step(0, 0, 0, 0, 0);
    step(1, 1, 6, 2, 64'd600);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    // R7 resize in linear mode on width change
    step(1, 1, 4, 2, 64'd1280);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    // R10 eight-byte write across two words
    rd_tag = "R10";
    step(1, 1, 0, 8, 64'h0258_0320_00AA_BB11);
    step(1, 0, 0, 8, 0);
    step(1, 0, 4, 4, 0);
    step(0, 0, 0, 0, 0);
    // R1 out-of-window writes dropped, reads zero
    rd_tag = "R1";
    step(1, 1, 124, 4, 64'hDEAD_BEEF);
    step(1, 1, 122, 8, 64'h1122_3344_5566_7788);
    step(1, 1, 200, 1, 64'hFF);
    step(1, 0, 124, 8, 0);
    step(1, 0, 120, 8, 0);
    step(1, 0, 127, 1, 0);
    step(1, 0, 128, 1, 0);
    // R3 bad sizes
    rd_tag = "R3";
    step(1, 1, 16, 3, 64'hFFFF_FFFF);
    step(1, 1, 16, 0, 64'hFFFF_FFFF);
    step(1, 0, 16, 8, 0);
    step(1, 0, 16, 3, 0);
    // back-to-back: zero both then immediately non-zero
    rd_tag = "R2";
    step(1, 1, 4, 4, 64'h0);
    step(1, 1, 4, 4, 64'h0010_0020);
    step(1, 1, 4, 4, 64'h0);
    step(0, 0, 0, 0, 0);
    // random mix
    for (int n = 0; n < 4000; n++) begin
      int a, s, r;
      logic [63:0] d;
      r = $urandom % 8;
      s = (r < 2) ? 1 : (r < 4) ? 2 : (r < 6) ? 4 : (r == 6) ? 8 : ($urandom % 16);
      a = ($urandom % 2) ? ($urandom % 12) : ($urandom % 140);
      d = ($urandom % 3 == 0) ? 64'd0 : {$urandom, $urandom};
      if ($urandom % 4 == 0) d[15:0] = 16'd0;
      step(($urandom % 5) != 0, $urandom % 2, a, s, d);
    end
    summary();
    $finish;
  end
endmodule